// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the digital setting of a 512-position input delay line. A 9-bit tap register sits on a control clock. Its value can be kept constant, moved one position at a time, or replaced with a parallel word. The live setting is driven on a monitor output, so downstream logic can see which tap is in use. A delay-reset input puts the register back to an elaboration-time preset. The preset is written either as a number of taps or as a time in picoseconds, which is converted to taps.

Three behaviours can be built: `DLY_STATIC` ignores every control pin except the delay reset. `DLY_STEP` moves the tap up or down by one. `DLY_LOAD` also accepts a parallel word. In `DLY_LOAD` a manual option holds a loaded word in a staging register and applies it only on a later commit. A cascade option adds a second lane with its own clock, controls, preset and polarity settings, and a sum output gives the combined tap count. The clock and the delay reset of each lane have a polarity parameter.

The staging logic in each lane is a two-state machine:
- `ST_TRACK`: nothing is staged.
- `ST_STAGED`: a word is waiting to be committed.

It has four transitions:
- capture, `ST_TRACK`→`ST_STAGED`: `load` high and `ce` low.
- recapture, `ST_STAGED`→`ST_STAGED`: `load` high and `ce` low; this replaces the staged word.
- commit, `ST_STAGED`→`ST_TRACK`: `load` and `ce` both high; this writes the staged word to the tap.
- discard, any state→`ST_TRACK`: delay reset.

Top module: `dly_tap_ctrl`

## Requirements
- R1: While the delay reset is at its active level (high, or low when its polarity parameter is set), each clock edge sets the tap to the preset. A count-format preset above 511 is clamped to 511.
- R2: For a time-format preset P in ps, the reset value is floor(P*511/1250), clamped to 511.
- R3: In `DLY_STATIC` mode, `ce`, `inc`, `load` and `tap_in` leave the tap unchanged.
- R4: In `DLY_STEP` mode, and in `DLY_LOAD` mode when no load applies, `ce`=1 with `inc`=1 adds one to the tap and `ce`=1 with `inc`=0 subtracts one. The result shows on `tap_out` after the next active edge. In `DLY_STEP` mode `load` is ignored.
- R5: Stepping saturates: an increment at 511 stays at 511 and a decrement at 0 stays at 0.
- R6: In `DLY_LOAD` mode without the manual option, `load`=1 writes `tap_in` to the tap at the next edge and takes priority over stepping.
- R7: In manual `DLY_LOAD` mode:
  - `load`=1 with `ce`=0 stages `tap_in` and does not change the tap.
  - A later `load`=1 with `ce`=1 writes the staged word, and the stage becomes empty.
  - `load`=1 with `ce`=1 while nothing is staged has no effect.
  - `ce`=1 without `load` steps the tap as in R4 and keeps the staged word.
- R8: The delay reset empties the staging register, so a word staged before the reset is never committed.
- R9: With cascade enabled, the second lane follows R1 to R7 from its own pins, and `tap_sum` equals `tap_out` plus `tap_out_x`. With cascade disabled, `tap_out_x` reads 0 and `tap_sum` equals `tap_out`.
- R10: With the clock polarity parameter set, the lane updates on the falling edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, main lane |
| rst_dly | input | 1 | Delay reset, main lane (polarity by parameter) |
| ce | input | 1 | Step enable / commit qualifier, main lane |
| inc | input | 1 | Step direction: 1 up, 0 down |
| load | input | 1 | Parallel load / stage request |
| tap_in | input | 9 | Parallel tap word |
| tap_out | output | 9 | Live tap value, main lane |
| clk_x | input | 1 | Control clock, cascaded lane |
| rst_dly_x | input | 1 | Delay reset, cascaded lane |
| ce_x | input | 1 | Step enable, cascaded lane |
| inc_x | input | 1 | Step direction, cascaded lane |
| load_x | input | 1 | Load request, cascaded lane |
| tap_in_x | input | 9 | Parallel tap word, cascaded lane |
| tap_out_x | output | 9 | Live tap value, cascaded lane (0 when cascade is off) |
| tap_sum | output | 10 | Sum of both lane taps |

## Verification
The hardest case to reach is the manual lane's staging register. A staged word can be recapted, committed, discarded by a reset, or stay in place while the tap steps, and only the later commit makes any of this visible at the ports. The stimulus drives `load`, `ce`, `inc` and reset from a pseudo-random stream, with `load` frequent and reset rare. This produces long runs of stage, step and commit in many orders, and every cycle is compared with a bench model that tracks the staged word. Saturation is reached with directed runs of 600 increments and then 600 decrements. Every load value from 0 to 511 is swept through the immediate-load lane.

// File: rtl/dly_tap_pkg.sv
package dly_tap_pkg;

    localparam int unsigned FULL_SCALE_PS = 1250;

    typedef enum logic [1:0] {
        DLY_STATIC = 2'd0,
        DLY_STEP   = 2'd1,
        DLY_LOAD   = 2'd2
    } dly_kind_e;

    typedef enum logic {
        ST_TRACK  = 1'b0,
        ST_STAGED = 1'b1
    } stage_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_SET,
        ACT_PRESET
    } tap_act_e;

    // Preset in taps: ps values scale linearly onto the full tap range.
    function automatic int unsigned preset_to_taps(input int unsigned value,
                                                   input bit in_ps,
                                                   input int unsigned max_tap);
        int unsigned t;
        t = in_ps ? (value * max_tap) / FULL_SCALE_PS : value;
        return (t > max_tap) ? max_tap : t;
    endfunction

endpackage

// File: rtl/dly_tap_stage.sv
module dly_tap_stage
    import dly_tap_pkg::*;
#(
    parameter int        TAP_BITS = 9,
    parameter dly_kind_e KIND     = DLY_LOAD,
    parameter bit        MANUAL   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_act,
    input  logic                ce,
    input  logic                inc,
    input  logic                load,
    input  logic [TAP_BITS-1:0] val,
    output tap_act_e            act,
    output logic [TAP_BITS-1:0] act_val
);

    localparam bit STAGING = (KIND == DLY_LOAD) && MANUAL;

    stage_state_e        st_q, st_d;
    logic [TAP_BITS-1:0] stg_q;
    logic                cap;
    tap_act_e            step_act;

    // state register
    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst_act)  stg_q <= '0;
        else if (cap) stg_q <= val;
    end

    // next state
    always_comb begin
        st_d = st_q;
        cap  = 1'b0;
        if (rst_act) begin
            st_d = ST_TRACK;
        end else if (STAGING) begin
            unique case (st_q)
                ST_TRACK: begin
                    if (load && !ce) begin
                        st_d = ST_STAGED;
                        cap  = 1'b1;
                    end
                end
                ST_STAGED: begin
                    if (load && !ce)     cap  = 1'b1;
                    else if (load && ce) st_d = ST_TRACK;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        step_act = ce ? (inc ? ACT_UP : ACT_DOWN) : ACT_HOLD;
        act      = ACT_HOLD;
        act_val  = val;
        if (rst_act) begin
            act = ACT_PRESET;
        end else if (KIND == DLY_STEP) begin
            act = step_act;
        end else if (KIND == DLY_LOAD) begin
            if (STAGING) begin
                if (load && ce) begin
                    if (st_q == ST_STAGED) begin
                        act     = ACT_SET;
                        act_val = stg_q;
                    end
                end else if (!load) begin
                    act = step_act;
                end
            end else begin
                act = load ? ACT_SET : step_act;
            end
        end
    end

    generate
        if (STAGING) begin : g_stage_chk
            AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (rst_act)
                (load && !ce) |=> (st_q == ST_STAGED)); // R7
            AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (rst_act)
                (st_q == ST_STAGED && load && ce) |=> (st_q == ST_TRACK)); // R7
        end
    endgenerate

    AST_RESET_DISCARDS: assert property (@(posedge clk) disable iff (rst_act)
        $fell(rst_act) |-> (st_q == ST_TRACK)); // R8

endmodule

// File: rtl/dly_tap_counter.sv
module dly_tap_counter
    import dly_tap_pkg::*;
#(
    parameter int          TAP_BITS  = 9,
    parameter int unsigned PRESET    = 0,
    parameter bit          PRESET_PS = 1'b0
) (
    input  logic                clk,
    input  logic                rst_act,
    input  tap_act_e            act,
    input  logic [TAP_BITS-1:0] val,
    output logic [TAP_BITS-1:0] tap
);

    localparam int unsigned         MAX_TAP_I  = (1 << TAP_BITS) - 1;
    localparam logic [TAP_BITS-1:0] MAX_TAP    = TAP_BITS'(MAX_TAP_I);
    localparam logic [TAP_BITS-1:0] PRESET_TAP =
        TAP_BITS'(preset_to_taps(PRESET, PRESET_PS, MAX_TAP_I));

    logic [TAP_BITS-1:0] tap_q;

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_PRESET: tap_q <= PRESET_TAP;
            ACT_SET:    tap_q <= val;
            ACT_UP:     if (tap_q != MAX_TAP) tap_q <= tap_q + 1'b1;
            ACT_DOWN:   if (tap_q != '0)      tap_q <= tap_q - 1'b1;
            ACT_HOLD:   ;
            default:    ;
        endcase
    end

    assign tap = tap_q;

    AST_PRESET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst_act)
        $fell(rst_act) |-> (tap_q == PRESET_TAP)); // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_UP && tap_q != MAX_TAP) |=> (tap_q == $past(tap_q) + 1'b1)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_DOWN && tap_q != '0) |=> (tap_q == $past(tap_q) - 1'b1)); // R4
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_UP && tap_q == MAX_TAP) |=> (tap_q == MAX_TAP)); // R5
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_DOWN && tap_q == '0) |=> (tap_q == '0)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_HOLD) |=> $stable(tap_q)); // R3
    AST_SET_VALUE: assert property (@(posedge clk) disable iff (rst_act)
        (act == ACT_SET) |=> (tap_q == $past(val))); // R6

endmodule

// File: rtl/dly_tap_lane.sv
module dly_tap_lane
    import dly_tap_pkg::*;
#(
    parameter int          TAP_BITS  = 9,
    parameter dly_kind_e   KIND      = DLY_LOAD,
    parameter int unsigned PRESET    = 0,
    parameter bit          PRESET_PS = 1'b0,
    parameter bit          MANUAL    = 1'b0,
    parameter bit          CLK_INV   = 1'b0,
    parameter bit          RST_INV   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_dly,
    input  logic                ce,
    input  logic                inc,
    input  logic                load,
    input  logic [TAP_BITS-1:0] tap_in,
    output logic [TAP_BITS-1:0] tap_out
);

    logic                ck;
    logic                rst_act;
    tap_act_e            act;
    logic [TAP_BITS-1:0] act_val;

    assign ck      = clk ^ CLK_INV;
    assign rst_act = rst_dly ^ RST_INV;

    dly_tap_stage #(
        .TAP_BITS (TAP_BITS),
        .KIND     (KIND),
        .MANUAL   (MANUAL)
    ) u_stage (
        .clk     (ck),
        .rst_act (rst_act),
        .ce      (ce),
        .inc     (inc),
        .load    (load),
        .val     (tap_in),
        .act     (act),
        .act_val (act_val)
    );

    dly_tap_counter #(
        .TAP_BITS  (TAP_BITS),
        .PRESET    (PRESET),
        .PRESET_PS (PRESET_PS)
    ) u_counter (
        .clk     (ck),
        .rst_act (rst_act),
        .act     (act),
        .val     (act_val),
        .tap     (tap_out)
    );

endmodule

// File: rtl/dly_tap_ctrl.sv
module dly_tap_ctrl
    import dly_tap_pkg::*;
#(
    parameter int          TAP_BITS    = 9,
    parameter dly_kind_e   KIND        = DLY_LOAD,
    parameter int unsigned PRESET      = 0,
    parameter bit          PRESET_PS   = 1'b0,
    parameter bit          MANUAL      = 1'b0,
    parameter bit          CLK_INV     = 1'b0,
    parameter bit          RST_INV     = 1'b0,
    parameter bit          CASCADE     = 1'b0,
    parameter dly_kind_e   KIND_X      = DLY_LOAD,
    parameter int unsigned PRESET_X    = 0,
    parameter bit          PRESET_X_PS = 1'b0,
    parameter bit          MANUAL_X    = 1'b0,
    parameter bit          CLK_X_INV   = 1'b0,
    parameter bit          RST_X_INV   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_dly,
    input  logic                ce,
    input  logic                inc,
    input  logic                load,
    input  logic [TAP_BITS-1:0] tap_in,
    output logic [TAP_BITS-1:0] tap_out,
    input  logic                clk_x,
    input  logic                rst_dly_x,
    input  logic                ce_x,
    input  logic                inc_x,
    input  logic                load_x,
    input  logic [TAP_BITS-1:0] tap_in_x,
    output logic [TAP_BITS-1:0] tap_out_x,
    output logic [TAP_BITS:0]   tap_sum
);

    logic [TAP_BITS-1:0] tap_x_w;

    dly_tap_lane #(
        .TAP_BITS  (TAP_BITS),
        .KIND      (KIND),
        .PRESET    (PRESET),
        .PRESET_PS (PRESET_PS),
        .MANUAL    (MANUAL),
        .CLK_INV   (CLK_INV),
        .RST_INV   (RST_INV)
    ) u_lane_main (
        .clk     (clk),
        .rst_dly (rst_dly),
        .ce      (ce),
        .inc     (inc),
        .load    (load),
        .tap_in  (tap_in),
        .tap_out (tap_out)
    );

    generate
        if (CASCADE) begin : g_cascade
            dly_tap_lane #(
                .TAP_BITS  (TAP_BITS),
                .KIND      (KIND_X),
                .PRESET    (PRESET_X),
                .PRESET_PS (PRESET_X_PS),
                .MANUAL    (MANUAL_X),
                .CLK_INV   (CLK_X_INV),
                .RST_INV   (RST_X_INV)
            ) u_lane_ext (
                .clk     (clk_x),
                .rst_dly (rst_dly_x),
                .ce      (ce_x),
                .inc     (inc_x),
                .load    (load_x),
                .tap_in  (tap_in_x),
                .tap_out (tap_x_w)
            );
        end else begin : g_single
            logic unused_x_pins;
            assign unused_x_pins = ^{clk_x, rst_dly_x, ce_x, inc_x, load_x, tap_in_x};
            assign tap_x_w = '0;
        end
    endgenerate

    assign tap_out_x = tap_x_w;
    assign tap_sum   = {1'b0, tap_out} + {1'b0, tap_x_w};

endmodule

// File: tb/test_dly_tap_ctrl.sv
module test_dly_tap_ctrl;
    import dly_tap_pkg::*;

    localparam int NFIX = 4;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       ce    = 1'b0;
    logic       inc   = 1'b0;
    logic       ld    = 1'b0;
    logic [8:0] tin   = '0;
    logic       rst_x = 1'b1;
    logic       ce_x  = 1'b0;
    logic       inc_x = 1'b0;
    logic       ld_x  = 1'b0;
    logic [8:0] tin_x = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    // A: immediate load lane with a stepping cascaded lane (ps preset, active-low reset)
    logic [8:0] a_tap, a_tapx;
    logic [9:0] a_sum;
    dly_tap_ctrl #(
        .KIND(DLY_LOAD), .PRESET(100), .PRESET_PS(1'b0), .MANUAL(1'b0),
        .CASCADE(1'b1), .KIND_X(DLY_STEP), .PRESET_X(1000), .PRESET_X_PS(1'b1),
        .RST_X_INV(1'b1)
    ) i_dly_tap_ctrl (
        .clk(clk), .rst_dly(rst), .ce(ce), .inc(inc), .load(ld), .tap_in(tin),
        .tap_out(a_tap), .clk_x(clk), .rst_dly_x(~rst_x), .ce_x(ce_x), .inc_x(inc_x),
        .load_x(ld_x), .tap_in_x(tin_x), .tap_out_x(a_tapx), .tap_sum(a_sum)
    );

    // B: static lanes with ps presets k*416
    logic [8:0] b_tap  [NFIX];
    logic [8:0] b_tapx [NFIX];
    logic [9:0] b_sum  [NFIX];
    for (genvar k = 0; k < NFIX; k++) begin : g_fix
        dly_tap_ctrl #(
            .KIND(DLY_STATIC), .PRESET(k * 416), .PRESET_PS(1'b1)
        ) i_dly_tap_ctrl (
            .clk(clk), .rst_dly(rst), .ce(ce), .inc(inc), .load(ld), .tap_in(tin),
            .tap_out(b_tap[k]), .clk_x(clk), .rst_dly_x(rst_x), .ce_x(ce_x),
            .inc_x(inc_x), .load_x(ld_x), .tap_in_x(tin_x), .tap_out_x(b_tapx[k]),
            .tap_sum(b_sum[k])
        );
    end

    // C: stepping lane, falling-edge clock, active-low reset
    logic [8:0] c_tap, c_tapx;
    logic [9:0] c_sum;
    dly_tap_ctrl #(
        .KIND(DLY_STEP), .PRESET(510), .CLK_INV(1'b1), .RST_INV(1'b1)
    ) i_dly_tap_ctrl_neg (
        .clk(clk), .rst_dly(~rst), .ce(ce), .inc(inc), .load(ld), .tap_in(tin),
        .tap_out(c_tap), .clk_x(clk), .rst_dly_x(rst_x), .ce_x(ce_x), .inc_x(inc_x),
        .load_x(ld_x), .tap_in_x(tin_x), .tap_out_x(c_tapx), .tap_sum(c_sum)
    );

    // D: manual staged load, count preset above range
    logic [8:0] d_tap, d_tapx;
    logic [9:0] d_sum;
    dly_tap_ctrl #(
        .KIND(DLY_LOAD), .PRESET(700), .MANUAL(1'b1)
    ) i_dly_tap_ctrl_man (
        .clk(clk), .rst_dly(rst), .ce(ce), .inc(inc), .load(ld), .tap_in(tin),
        .tap_out(d_tap), .clk_x(clk), .rst_dly_x(rst_x), .ce_x(ce_x), .inc_x(inc_x),
        .load_x(ld_x), .tap_in_x(tin_x), .tap_out_x(d_tapx), .tap_sum(d_sum)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // kind: 0 static, 1 step, 2 load
    task automatic model(input int kind, input bit man, input int pre,
                         input bit r, input bit c, input bit i, input bit l,
                         input int v, inout int cur, inout bit sv, inout int sg);
        int stepped;
        stepped = cur;
        if (c) stepped = i ? ((cur < 511) ? cur + 1 : 511) : ((cur > 0) ? cur - 1 : 0);
        if (r) begin
            cur = pre;
            sv  = 1'b0;
        end else if (kind == 1) begin
            cur = stepped;
        end else if (kind == 2) begin
            if (!man) begin
                cur = l ? v : stepped;
            end else if (l && c) begin
                if (sv) begin
                    cur = sg;
                    sv  = 1'b0;
                end
            end else if (l) begin
                sg = v;
                sv = 1'b1;
            end else begin
                cur = stepped;
            end
        end
    endtask

    function automatic int ps_taps(input int ps);
        int t;
        t = (ps * 511) / 1250;
        return (t > 511) ? 511 : t;
    endfunction

    task automatic run_all();
        int a_m = 0, ax_m = 0, c_m = 0, d_m = 0, a_prev;
        bit a_sv = 0, ax_sv = 0, c_sv = 0, d_sv = 0;
        int a_sg = 0, ax_sg = 0, c_sg = 0, d_sg = 0;
        int b_exp [NFIX];
        logic [31:0] x = 32'h1234_5678;
        for (int k = 0; k < NFIX; k++) b_exp[k] = ps_taps(k * 416);
        for (int cyc = 0; cyc < 5720; cyc++) begin
            @(posedge clk);
            #1;
            if (cyc > 0) begin
                check("R6 load lane", int'(a_tap), a_m);
                check("R9 cascaded lane", int'(a_tapx), ax_m);
                check("R9 tap_sum", int'(a_sum), a_m + ax_m);
                for (int k = 0; k < NFIX; k++) begin
                    check("R3 static lane", int'(b_tap[k]), b_exp[k]);
                    check("R9 cascade off", int'(b_tapx[k]), 0);
                end
                check("R9 sum single lane", int'(d_sum), int'(d_tap));
                check("R4 step lane", int'(c_tap), c_m);
                check("R7 manual lane", int'(d_tap), d_m);
            end
            if (cyc == 4) begin
                check("R1 preset count", int'(a_tap), 100);
                check("R1 clamp preset", int'(d_tap), 511);
                check("R1 active-low reset", int'(c_tap), 510);
                check("R2 ps preset 1000", int'(a_tapx), 408);
                check("R2 ps preset 416", int'(b_tap[1]), 170);
                check("R2 ps preset 1248", int'(b_tap[3]), 510);
            end
            if (cyc == 1116) begin
                check("R5 saturate high", int'(a_tap), 511);
                check("R5 saturate high neg", int'(c_tap), 511);
            end
            if (cyc == 1716) begin
                check("R5 saturate low", int'(a_tap), 0);
                check("R5 saturate low neg", int'(c_tap), 0);
            end
            // stimulus
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            rst_x = (cyc < 4) || (x[31:27] == 5'd0);
            ce_x  = x[20];
            inc_x = x[21];
            ld_x  = x[22];
            tin_x = x[8:0];
            if (cyc < 4) begin
                rst = 1; ce = 0; inc = 0; ld = 0; tin = '0;
            end else if (cyc < 516) begin
                rst = 0; ld = 1; tin = 9'(cyc - 4);
                ce = tin[0]; inc = tin[1];
            end else if (cyc < 1116) begin
                rst = (cyc == 516); ce = 1; inc = 1; ld = 0; tin = x[16:8];
            end else if (cyc < 1716) begin
                rst = 0; ce = 1; inc = 0; ld = 0; tin = x[16:8];
            end else begin
                rst = (x[26:22] == 5'd0); ce = x[0]; inc = x[1] | x[2];
                ld = x[3] & x[4]; tin = x[17:9];
            end
            a_prev = a_m;
            model(2, 0, 100, rst, ce, inc, ld, int'(tin), a_m, a_sv, a_sg);
            model(1, 0, 408, rst_x, ce_x, inc_x, ld_x, int'(tin_x), ax_m, ax_sv, ax_sg);
            model(1, 0, 510, rst, ce, inc, ld, int'(tin), c_m, c_sv, c_sg);
            model(2, 1, 511, rst, ce, inc, ld, int'(tin), d_m, d_sv, d_sg);
            #2;
            if (cyc > 0) begin
                check("R10 falling-edge update", int'(c_tap), c_m);
                check("R10 rising lane not yet", int'(a_tap), a_prev);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                #(4 * 150000);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule